// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block holds the per-channel error flags, completion interrupt flags and interrupt enables for a scatter-gather DMA engine that moves data in two directions. It watches four kinds of input for each channel: the completion pulses of the write list and the read list, the bus abort indications, the direction bit carried in the next pointer of each chaining descriptor, and an external interrupt line. From these it keeps sticky flags. It combines the flags with a small per-channel control register into one interrupt status bit, which is also the channel's system interrupt output.

Software loads the control register with a per-channel write strobe. It clears latched flags by writing ones to their bit positions, and a strobe selects the channel. The descriptor fetch engine and the bus master sit outside this block. They only deliver pulses to it. Every output is registered. Inputs present before a rising clock edge are reflected on the outputs right after that edge.

Top module: `dmaint_status_ctrl`

## Requirements
- R1: An abort pulse (`abort_tgt` or `abort_mst`) sets the write-error flag (status bit 0) when `xfer_rd` is 0. It sets the read-error flag (status bit 1) when `xfer_rd` is 1.
- R2: A descriptor check on the write list (`desc_chk_wr`) with `desc_dir`=1 sets the write-error flag. A check on the read list (`desc_chk_rd`) with `desc_dir`=0 sets the read-error flag. A check whose direction matches its list changes nothing.
- R3: `wr_done` sets the write-completion flag (status bit 2) and `rd_done` sets the read-completion flag (status bit 3). Each flag stays set until software clears it.
- R4: With `clr_we` high for a channel, each 1 in `clr_mask` clears the flag at the same bit position (0 write error, 1 read error, 2 write completion, 3 read completion). A 0 in the mask leaves its flag unchanged. A set event in the same cycle as a clear wins, so the flag stays set.
- R5: The control word `ctl_wdata` has bit 0 = master enable, bit 1 = external enable and bit 2 = force. It is loaded on `ctl_we`. Status bit 4 (local active) equals the force bit. Force raises the interrupt only while master enable is 1.
- R6: Status bit 5 (external active) follows `ext_irq`. The external line raises the interrupt only while the external enable is 1.
- R7: The completion flags raise the interrupt only while master enable is 1. The error flags never raise it.
- R8: Status bit 6 and `irq_o` for a channel are 1 exactly when some enabled condition is active. `irq_any_o` is the OR of all channels.
- R9: Synchronous reset clears all flags, all control bits and all outputs.
- R10: All outputs change one clock edge after their causing inputs. Channels are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_done | input | NCH | Write scatter-gather list completed, per channel |
| rd_done | input | NCH | Read scatter-gather list completed, per channel |
| abort_tgt | input | NCH | Target abort seen on the bus |
| abort_mst | input | NCH | Master abort seen on the bus |
| xfer_rd | input | NCH | Running transfer is a read (1) or a write (0) |
| desc_chk_wr | input | NCH | Descriptor next pointer fetched on the write list |
| desc_chk_rd | input | NCH | Descriptor next pointer fetched on the read list |
| desc_dir | input | NCH | Direction bit of the fetched next pointer |
| ext_irq | input | NCH | External interrupt line |
| ctl_we | input | NCH | Control register write strobe |
| ctl_wdata | input | 3 | Control word: master enable, external enable, force |
| clr_we | input | NCH | Write-one-to-clear strobe |
| clr_mask | input | 4 | Flags to clear |
| stat_o | output | NCH*7 | Per-channel status, 7 bits per channel |
| irq_o | output | NCH | Per-channel system interrupt |
| irq_any_o | output | 1 | OR of all channel interrupts |

## Verification
The assertions check on every cycle that each abort, descriptor mismatch and completion pulse produces its flag on the next edge. They also check that a clear with no set event empties its bit, that idle flags hold, and that an enabled force or external source always shows up as an interrupt. The bench's scenarios are needed for the rest. These are the negative cases: matching descriptor directions leave the flags alone, error flags alone never interrupt, and enables gate their sources. They also cover the exact priority of a set over a clear in the same cycle and the independence of the two channels. Random runs compare every status bit against a bench model on every cycle.

// File: rtl/dmaint_pkg.sv
package dmaint_pkg;
  localparam int ST_WERR = 0;
  localparam int ST_RERR = 1;
  localparam int ST_WINT = 2;
  localparam int ST_RINT = 3;
  localparam int ST_LOC  = 4;
  localparam int ST_EXT  = 5;
  localparam int ST_INT  = 6;
  localparam int ST_W    = 7;
  localparam int FLAG_W  = 4;
  localparam int CF_W    = 3;

  typedef struct packed {
    logic frc;
    logic xen;
    logic men;
  } ctl_t;
endpackage

// File: rtl/dmaint_flag_latch.sv
module dmaint_flag_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_comb nxt_o = (q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;

  // R3: a set event is visible on the next edge
  p_set_visible_r3: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));

  // R4: a clear without a competing set empties the bit
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((q & $past(clr_i & ~set_i)) == '0));

  // R3: flags hold when nothing touches them
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(q));
endmodule

// File: rtl/dmaint_chan.sv
module dmaint_chan
  import dmaint_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_done,
  input  logic            rd_done,
  input  logic            abort_tgt,
  input  logic            abort_mst,
  input  logic            xfer_rd,
  input  logic            desc_chk_wr,
  input  logic            desc_chk_rd,
  input  logic            desc_dir,
  input  logic            ext_irq,
  input  logic            ctl_we,
  input  logic [CF_W-1:0] ctl_wdata,
  input  logic            clr_we,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [ST_W-1:0] stat_o,
  output logic            int_nxt_o,
  output logic            int_o
);
  ctl_t ctl_q, ctl_nxt;
  logic ext_q;
  logic int_q;
  logic any_abort;
  logic werr_set, rerr_set;
  logic [FLAG_W-1:0] fl_set, fl_clr, fl_nxt, fl_q;

  always_comb begin
    any_abort = abort_tgt | abort_mst;
    werr_set  = (any_abort & ~xfer_rd) | (desc_chk_wr &  desc_dir);
    rerr_set  = (any_abort &  xfer_rd) | (desc_chk_rd & ~desc_dir);
    fl_set    = '0;
    fl_set[ST_WERR] = werr_set;
    fl_set[ST_RERR] = rerr_set;
    fl_set[ST_WINT] = wr_done;
    fl_set[ST_RINT] = rd_done;
    fl_clr    = clr_we ? clr_mask : '0;
  end

  dmaint_flag_latch #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (fl_set),
    .clr_i (fl_clr),
    .nxt_o (fl_nxt),
    .q_o   (fl_q)
  );

  always_comb begin
    ctl_nxt = ctl_we ? ctl_t'(ctl_wdata) : ctl_q;
    int_nxt_o = (ctl_nxt.men & (ctl_nxt.frc | fl_nxt[ST_WINT] | fl_nxt[ST_RINT]))
              | (ctl_nxt.xen & ext_irq);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ext_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      ext_q <= ext_irq;
      int_q <= int_nxt_o;
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[FLAG_W-1:0] = fl_q;
    stat_o[ST_LOC]     = ctl_q.frc;
    stat_o[ST_EXT]     = ext_q;
    stat_o[ST_INT]     = int_q;
  end
  assign int_o = int_q;

  p_abort_wr_r1: assert property (@(posedge clk) disable iff (rst)
    (any_abort && !xfer_rd) |=> fl_q[ST_WERR]);
  p_abort_rd_r1: assert property (@(posedge clk) disable iff (rst)
    (any_abort && xfer_rd) |=> fl_q[ST_RERR]);
  p_desc_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (desc_chk_wr && desc_dir) |=> fl_q[ST_WERR]);
  p_desc_rd_r2: assert property (@(posedge clk) disable iff (rst)
    (desc_chk_rd && !desc_dir) |=> fl_q[ST_RERR]);
  p_force_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.frc && ctl_q.men) |-> int_q);
  p_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (ext_q && ctl_q.xen) |-> int_q);
  p_err_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.frc && !fl_q[ST_WINT] && !fl_q[ST_RINT] && !ext_q) |-> !int_q);
  p_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    int_q |-> (ctl_q.men || ctl_q.xen));
endmodule

// File: rtl/dmaint_status_ctrl.sv
module dmaint_status_ctrl
  import dmaint_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      wr_done,
  input  logic [NCH-1:0]      rd_done,
  input  logic [NCH-1:0]      abort_tgt,
  input  logic [NCH-1:0]      abort_mst,
  input  logic [NCH-1:0]      xfer_rd,
  input  logic [NCH-1:0]      desc_chk_wr,
  input  logic [NCH-1:0]      desc_chk_rd,
  input  logic [NCH-1:0]      desc_dir,
  input  logic [NCH-1:0]      ext_irq,
  input  logic [NCH-1:0]      ctl_we,
  input  logic [CF_W-1:0]     ctl_wdata,
  input  logic [NCH-1:0]      clr_we,
  input  logic [FLAG_W-1:0]   clr_mask,
  output logic [NCH*ST_W-1:0] stat_o,
  output logic [NCH-1:0]      irq_o,
  output logic                irq_any_o
);
  logic [NCH-1:0] int_nxt;
  logic any_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmaint_chan u_ch (
      .clk         (clk),
      .rst         (rst),
      .wr_done     (wr_done[c]),
      .rd_done     (rd_done[c]),
      .abort_tgt   (abort_tgt[c]),
      .abort_mst   (abort_mst[c]),
      .xfer_rd     (xfer_rd[c]),
      .desc_chk_wr (desc_chk_wr[c]),
      .desc_chk_rd (desc_chk_rd[c]),
      .desc_dir    (desc_dir[c]),
      .ext_irq     (ext_irq[c]),
      .ctl_we      (ctl_we[c]),
      .ctl_wdata   (ctl_wdata),
      .clr_we      (clr_we[c]),
      .clr_mask    (clr_mask),
      .stat_o      (stat_o[c*ST_W +: ST_W]),
      .int_nxt_o   (int_nxt[c]),
      .int_o       (irq_o[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |int_nxt;
  end
  assign irq_any_o = any_q;

  p_any_matches_r8: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (irq_o != '0));
endmodule

// File: tb/dmaint_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmaint_status_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int SW  = 7;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] wr_done, rd_done, abort_tgt, abort_mst, xfer_rd;
  logic [NCH-1:0] desc_chk_wr, desc_chk_rd, desc_dir, ext_irq, ctl_we, clr_we;
  logic [2:0] ctl_wdata;
  logic [3:0] clr_mask;
  logic [NCH*SW-1:0] stat_o;
  logic [NCH-1:0] irq_o;
  logic irq_any_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] m_flg [NCH];
  logic [2:0] m_ctl [NCH];
  logic       m_ext [NCH];
  logic       m_int [NCH];

  always #2 clk = ~clk;

  dmaint_status_ctrl #(.NCH(NCH)) dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] flag_set(int c);
    logic ab = abort_tgt[c] | abort_mst[c];
    logic [3:0] s;
    s[0] = (ab & ~xfer_rd[c]) | (desc_chk_wr[c] & desc_dir[c]);
    s[1] = (ab & xfer_rd[c]) | (desc_chk_rd[c] & ~desc_dir[c]);
    s[2] = wr_done[c];
    s[3] = rd_done[c];
    return s;
  endfunction

  task automatic idle_inputs();
    wr_done = '0; rd_done = '0; abort_tgt = '0; abort_mst = '0; xfer_rd = '0;
    desc_chk_wr = '0; desc_chk_rd = '0; desc_dir = '0; ext_irq = '0;
    ctl_we = '0; clr_we = '0; ctl_wdata = '0; clr_mask = '0;
  endtask

  task automatic compare_all();
    logic any = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      chk("R1 R2 R4 error flags", int'(stat_o[c*SW +: 2]), int'(m_flg[c][1:0]));
      chk("R3 R4 completion flags", int'(stat_o[c*SW+2 +: 2]), int'(m_flg[c][3:2]));
      chk("R5 local active", int'(stat_o[c*SW+4]), int'(m_ctl[c][2]));
      chk("R6 external active", int'(stat_o[c*SW+5]), int'(m_ext[c]));
      chk("R7 R8 status int", int'(stat_o[c*SW+6]), int'(m_int[c]));
      chk("R8 irq_o", int'(irq_o[c]), int'(m_int[c]));
      any |= m_int[c];
    end
    chk("R8 irq_any", int'(irq_any_o), int'(any));
  endtask

  // one clock: model the edge, then compare after it (R10 latency)
  task automatic step();
    logic [3:0] nf [NCH];
    logic [2:0] nc [NCH];
    logic ne [NCH];
    logic ni [NCH];
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        nf[c] = '0; nc[c] = '0; ne[c] = 1'b0; ni[c] = 1'b0;
      end else begin
        nc[c] = ctl_we[c] ? ctl_wdata : m_ctl[c];
        nf[c] = (m_flg[c] & ~(clr_we[c] ? clr_mask : 4'h0)) | flag_set(c);
        ne[c] = ext_irq[c];
        ni[c] = (nc[c][0] & (nc[c][2] | nf[c][2] | nf[c][3])) | (nc[c][1] & ext_irq[c]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_flg[c] = nf[c]; m_ctl[c] = nc[c]; m_ext[c] = ne[c]; m_int[c] = ni[c];
    end
    compare_all();
    idle_inputs();
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    step(); step();
    // R9: reset state
    chk("R9 reset stat", int'(stat_o), 0);
    chk("R9 reset irq", int'({irq_any_o, irq_o}), 0);
    rst = 1'b0;

    // R1 abort during write on ch0, nothing on ch1 (R10 independence)
    abort_tgt[0] = 1'b1; step();
    chk("R1 werr ch0", int'(stat_o[0]), 1);
    chk("R10 ch1 untouched", int'(stat_o[SW +: SW]), 0);
    chk("R7 errors alone no irq", int'(irq_o[0]), 0);
    // R1 master abort during read
    abort_mst[0] = 1'b1; xfer_rd[0] = 1'b1; step();
    chk("R1 rerr ch0", int'(stat_o[1]), 1);
    // R2 matching directions: no effect on ch1
    desc_chk_wr[1] = 1'b1; desc_dir[1] = 1'b0; step();
    desc_chk_rd[1] = 1'b1; desc_dir[1] = 1'b1; step();
    chk("R2 matching dir ignored", int'(stat_o[SW +: 2]), 0);
    desc_chk_rd[1] = 1'b1; desc_dir[1] = 1'b0; step();
    chk("R2 read list dir0 error", int'(stat_o[SW+1]), 1);
    // R4 clear with set in same cycle: set wins
    clr_we[0] = 1'b1; clr_mask = 4'h3; abort_tgt[0] = 1'b1; step();
    chk("R4 set beats clear", int'(stat_o[1:0]), 1);
    clr_we[0] = 1'b1; clr_mask = 4'h0; step();
    chk("R4 zero mask keeps", int'(stat_o[0]), 1);
    // R3 + R7 completion gated by master enable
    wr_done[0] = 1'b1; step();
    chk("R7 completion no men", int'(irq_o[0]), 0);
    ctl_we[0] = 1'b1; ctl_wdata = 3'b001; step();
    chk("R7 completion with men", int'(irq_o[0]), 1);
    // R5 force without master enable
    ctl_we[1] = 1'b1; ctl_wdata = 3'b100; step();
    chk("R5 force no men", int'({stat_o[SW+4], irq_o[1]}), 2);
    // R6 external line gated by its enable
    ext_irq[1] = 1'b1; ctl_we[1] = 1'b1; ctl_wdata = 3'b010; step();
    chk("R6 ext enabled", int'(irq_o[1]), 1);
    step();
    chk("R6 ext dropped", int'(irq_o[1]), 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        wr_done[c]     = ($urandom % 8) == 0;
        rd_done[c]     = ($urandom % 8) == 0;
        abort_tgt[c]   = ($urandom % 20) == 0;
        abort_mst[c]   = ($urandom % 20) == 0;
        xfer_rd[c]     = $urandom % 2;
        desc_chk_wr[c] = ($urandom % 10) == 0;
        desc_chk_rd[c] = ($urandom % 10) == 0;
        desc_dir[c]    = $urandom % 2;
        ext_irq[c]     = ($urandom % 4) == 0;
        ctl_we[c]      = ($urandom % 12) == 0;
        clr_we[c]      = ($urandom % 3) == 0;
      end
      ctl_wdata = 3'($urandom);
      clr_mask  = 4'($urandom);
      rst = (($urandom % 500) == 0);
      step();
      rst = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule